// File: doc/BRIEF.md
# Transmit descriptor ring prefetcher

This block walks a circular ring of transmit buffer descriptors in memory and moves the frame data they point at into a transmit FIFO. Each descriptor is two 32-bit words. The first word holds a ready flag, an end-of-frame flag and a byte length. The second word holds the buffer address. The block reads a descriptor and then streams its buffer into the FIFO one word at a time. It issues a data read only when the FIFO has room for another word. When the buffer is done it moves straight on to the next descriptor, so it stays one descriptor ahead of the frame being sent.

Descriptors whose data has been moved wait in a small in-flight list. Each waits there until its first word has been written back to memory with the ready flag cleared. Reads take the shared memory port ahead of write-backs, so a write-back can lag behind the fetcher. When the ring wraps, the next index may therefore still be in the in-flight list. Its ready flag would still read as set, and the frame would go out twice. The fetcher does not read any index that is in the in-flight list until its write-back has completed.

When the fetcher finds a descriptor that is not ready, it stops. It starts again at that same index on the next start strobe.

Top module: `txring_prefetch`

## Requirements
- R1: After reset the block drives no memory request, no FIFO write and no length error, and its ring index is 0.
- R2: A start strobe while idle begins fetching at the current ring index. The first read after reset is to `ring_base`. A start strobe while fetching has no effect.
- R3: Descriptor i sits at `ring_base + 8*i`. In its first word, bit 31 is the ready flag, bit 27 is end of frame, and bits 10:0 are the length in bytes. The second word is the word-aligned buffer address.
- R4: A descriptor of length L yields ceil(L/4) FIFO writes. These are the words at buffer+4k, in increasing k. `fifo_eof` is high only on the final word of a descriptor whose end-of-frame flag is set, so a frame may span several descriptors.
- R5: A FIFO write happens only when `fifo_level + 4 <= fifo_bytes`. The FIFO capacity is the input `fifo_bytes`, 192 bytes in normal use.
- R6: A length field above 2032 is treated as 2032 bytes (508 words), and `len_err` pulses for one cycle for that descriptor.
- R7: Once all of a descriptor's data has been moved, its first word is written back with bit 31 cleared and every other bit unchanged. Write-backs go out in fetch order.
- R8: The ring index wraps to 0 after index `ring_cnt-1`. No descriptor at or beyond `ring_cnt` is read.
- R9: If a descriptor's first word has bit 31 clear, the block stops. It reads no buffer data and writes back nothing for that descriptor. The next start strobe resumes at the same index.
- R10: A descriptor index is never read again while an earlier fetch of it is still awaiting write-back. At most `INFL` descriptors await write-back.
- R11: Once raised, a memory request keeps its address and direction until acknowledged. Reads are preferred over write-backs.
- R12: A descriptor of length 0 makes no FIFO write and is still written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Strobe that resumes ring walking when idle |
| ring_base | input | 32 | Byte address of descriptor 0 |
| ring_cnt | input | IDXW | Number of descriptors in the ring (at least 1) |
| fifo_bytes | input | FLW | Transmit FIFO capacity in bytes |
| fifo_level | input | FLW | Current FIFO fill in bytes |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| fifo_wr | output | 1 | Push one word into the FIFO |
| fifo_data | output | 32 | Word pushed |
| fifo_eof | output | 1 | Pushed word ends a frame |
| len_err | output | 1 | Length field above 2032 was clamped |

## Verification
The assertions assume the following about the inputs:
- `ring_base`, `ring_cnt` and `fifo_bytes` do not change while the block is fetching.
- `fifo_level` rises only through this block's own writes.
- The memory responder acknowledges only requests that are present.

The bench memory answers every request one cycle after it appears. It updates the level at the same edge as each write. It drains the FIFO at a steady rate. The register fields are changed only after the block has gone quiet, either after reset or after the block has stopped on a descriptor that is not ready.

// File: rtl/txr_pkg.sv
package txr_pkg;

  localparam int unsigned BUF_MAX  = 2032;
  localparam int unsigned RDY_BIT  = 31;
  localparam int unsigned EOF_BIT  = 27;
  localparam int unsigned LEN_W    = 11;
  localparam int unsigned WCNT_W   = 10;

  typedef enum logic [1:0] {
    RS_IDLE,
    RS_W0,
    RS_W1,
    RS_DATA
  } rd_state_t;

  // byte address of one word of a descriptor
  function automatic logic [31:0] desc_addr(logic [31:0] base, logic [31:0] idx,
                                            logic second);
    return base + (idx << 3) + (second ? 32'd4 : 32'd0);
  endfunction

  function automatic logic over_len(logic [LEN_W-1:0] len);
    return 32'(len) > BUF_MAX;
  endfunction

  function automatic logic [LEN_W-1:0] clamp_len(logic [LEN_W-1:0] len);
    return over_len(len) ? LEN_W'(BUF_MAX) : len;
  endfunction

  // number of 32-bit words covering len bytes
  function automatic logic [WCNT_W-1:0] words_of(logic [LEN_W-1:0] len);
    logic [LEN_W:0] t;
    t = {1'b0, len} + (LEN_W+1)'(3);
    return t[LEN_W:2];
  endfunction

  function automatic logic [31:0] ring_next(logic [31:0] idx, logic [31:0] cnt);
    return ((idx + 32'd1) >= cnt) ? 32'd0 : idx + 32'd1;
  endfunction

endpackage

// File: rtl/txr_pending.sv
module txr_pending #(
  parameter int IDXW = 4,
  parameter int INFL = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [IDXW-1:0] push_idx,
  input  logic [31:0]     push_w0,
  input  logic            pop,
  input  logic [IDXW-1:0] probe_idx,
  output logic            probe_hit,
  output logic            full,
  output logic            empty,
  output logic [IDXW-1:0] head_idx,
  output logic [31:0]     head_w0
);

  localparam int PW = (INFL > 1) ? $clog2(INFL) : 1;

  logic [INFL-1:0] vld;
  logic [INFL-1:0] match;
  logic [IDXW-1:0] idx_m [INFL];
  logic [31:0]     w0_m  [INFL];
  logic [PW-1:0]   head, tail;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (32'(p) == INFL - 1) ? '0 : p + PW'(1);
  endfunction

  for (genvar g = 0; g < INFL; g++) begin : g_slot
    assign match[g] = vld[g] && (idx_m[g] == probe_idx);
  end

  assign probe_hit = |match;
  assign full      = &vld;
  assign empty     = ~|vld;
  assign head_idx  = idx_m[head];
  assign head_w0   = w0_m[head];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      head <= '0;
      tail <= '0;
    end else begin
      if (pop) begin
        vld[head] <= 1'b0;
        head      <= bump(head);
      end
      if (push) begin
        vld[tail]   <= 1'b1;
        idx_m[tail] <= push_idx;
        w0_m[tail]  <= push_w0;
        tail        <= bump(tail);
      end
    end
  end

endmodule

// File: rtl/txr_port_arb.sv
module txr_port_arb (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_req,
  input  logic [31:0] rd_addr,
  input  logic        wb_req,
  input  logic [31:0] wb_addr,
  input  logic [31:0] wb_data,
  input  logic        mem_ack,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        rd_ack,
  output logic        wb_ack
);

  logic hold_q, hold_wb_q, sel_wb;

  // an outstanding request keeps its owner; otherwise reads win
  assign sel_wb    = hold_q ? hold_wb_q : (!rd_req && wb_req);
  assign mem_req   = sel_wb ? wb_req : rd_req;
  assign mem_we    = sel_wb;
  assign mem_addr  = sel_wb ? wb_addr : rd_addr;
  assign mem_wdata = wb_data;
  assign rd_ack    = mem_ack && !sel_wb;
  assign wb_ack    = mem_ack && sel_wb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= 1'b0;
      hold_wb_q <= 1'b0;
    end else begin
      hold_q    <= mem_req && !mem_ack;
      hold_wb_q <= sel_wb;
    end
  end

endmodule

// File: rtl/txr_reader.sv
module txr_reader
  import txr_pkg::*;
#(
  parameter int IDXW = 4,
  parameter int FLW  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [31:0]     ring_base,
  input  logic [IDXW-1:0] ring_cnt,
  input  logic [FLW-1:0]  fifo_bytes,
  input  logic [FLW-1:0]  fifo_level,
  output logic            rd_req,
  output logic [31:0]     rd_addr,
  input  logic            rd_ack,
  input  logic [31:0]     rd_data,
  input  logic            list_hit,
  input  logic            list_full,
  output logic [IDXW-1:0] cur_idx,
  output logic            push,
  output logic [31:0]     push_w0,
  output logic            w0_done,
  output logic            fifo_wr,
  output logic [31:0]     fifo_data,
  output logic            fifo_eof,
  output logic            len_err
);

  rd_state_t         st;
  logic [IDXW-1:0]   idx;
  logic [31:0]       w0_q, ptr_q;
  logic [WCNT_W-1:0] nwords_q, k_q;
  logic              space_ok, last_word;
  logic [IDXW-1:0]   idx_nxt;
  logic [LEN_W-1:0]  len_in;

  assign space_ok  = ({1'b0, fifo_level} + (FLW+1)'(4)) <= {1'b0, fifo_bytes};
  assign last_word = (k_q == nwords_q - WCNT_W'(1));
  assign idx_nxt   = IDXW'(ring_next(32'(idx), 32'(ring_cnt)));
  assign len_in    = rd_data[LEN_W-1:0];

  always_comb begin
    rd_req  = 1'b0;
    rd_addr = desc_addr(ring_base, 32'(idx), 1'b0);
    unique case (st)
      RS_W0:   rd_req = !list_hit && !list_full;
      RS_W1: begin
        rd_req  = 1'b1;
        rd_addr = desc_addr(ring_base, 32'(idx), 1'b1);
      end
      RS_DATA: begin
        rd_req  = space_ok;
        rd_addr = ptr_q + {20'd0, k_q, 2'b00};
      end
      default: rd_req = 1'b0;
    endcase
  end

  assign w0_done   = (st == RS_W0) && rd_ack;
  assign len_err   = w0_done && rd_data[RDY_BIT] && over_len(len_in);
  assign fifo_wr   = (st == RS_DATA) && rd_ack;
  assign fifo_data = rd_data;
  assign fifo_eof  = fifo_wr && last_word && w0_q[EOF_BIT];
  assign push      = ((st == RS_W1) && rd_ack && (nwords_q == '0)) ||
                     (fifo_wr && last_word);
  assign push_w0   = w0_q;
  assign cur_idx   = idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= RS_IDLE;
      idx      <= '0;
      w0_q     <= '0;
      ptr_q    <= '0;
      nwords_q <= '0;
      k_q      <= '0;
    end else begin
      unique case (st)
        RS_IDLE: if (start) st <= RS_W0;
        RS_W0: if (rd_ack) begin
          if (!rd_data[RDY_BIT]) begin
            st <= RS_IDLE;
          end else begin
            w0_q     <= rd_data;
            nwords_q <= words_of(clamp_len(len_in));
            st       <= RS_W1;
          end
        end
        RS_W1: if (rd_ack) begin
          ptr_q <= rd_data;
          k_q   <= '0;
          if (nwords_q == '0) begin
            idx <= idx_nxt;
            st  <= RS_W0;
          end else begin
            st  <= RS_DATA;
          end
        end
        RS_DATA: if (rd_ack) begin
          k_q <= k_q + WCNT_W'(1);
          if (last_word) begin
            idx <= idx_nxt;
            st  <= RS_W0;
          end
        end
        default: st <= RS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/txring_prefetch.sv
module txring_prefetch
  import txr_pkg::*;
#(
  parameter int IDXW = 4,
  parameter int INFL = 2,
  parameter int FLW  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [31:0]     ring_base,
  input  logic [IDXW-1:0] ring_cnt,
  input  logic [FLW-1:0]  fifo_bytes,
  input  logic [FLW-1:0]  fifo_level,
  output logic            mem_req,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic            mem_ack,
  input  logic [31:0]     mem_rdata,
  output logic            fifo_wr,
  output logic [31:0]     fifo_data,
  output logic            fifo_eof,
  output logic            len_err
);

  // named events for the checker
  logic            ev_push, ev_pop, ev_w0_done;
  logic [IDXW-1:0] rd_cur_idx, wb_idx;

  logic        rd_req, rd_ack, wb_req, wb_ack;
  logic [31:0] rd_addr, push_w0, head_w0, wb_addr, wb_data;
  logic        list_hit, list_full, list_empty;

  txr_reader #(.IDXW(IDXW), .FLW(FLW)) u_reader (
    .clk, .rst_n, .start, .ring_base, .ring_cnt, .fifo_bytes, .fifo_level,
    .rd_req, .rd_addr, .rd_ack, .rd_data(mem_rdata),
    .list_hit, .list_full, .cur_idx(rd_cur_idx),
    .push(ev_push), .push_w0, .w0_done(ev_w0_done),
    .fifo_wr, .fifo_data, .fifo_eof, .len_err
  );

  txr_pending #(.IDXW(IDXW), .INFL(INFL)) u_pending (
    .clk, .rst_n, .push(ev_push), .push_idx(rd_cur_idx), .push_w0,
    .pop(ev_pop), .probe_idx(rd_cur_idx), .probe_hit(list_hit),
    .full(list_full), .empty(list_empty), .head_idx(wb_idx), .head_w0
  );

  assign wb_req  = !list_empty;
  assign wb_addr = desc_addr(ring_base, 32'(wb_idx), 1'b0);
  assign wb_data = head_w0 & ~(32'd1 << RDY_BIT);
  assign ev_pop  = wb_ack;

  txr_port_arb u_arb (
    .clk, .rst_n, .rd_req, .rd_addr, .wb_req, .wb_addr, .wb_data,
    .mem_ack, .mem_req, .mem_we, .mem_addr, .mem_wdata, .rd_ack, .wb_ack
  );

endmodule

// File: rtl/txr_checker.sv
module txr_checker #(
  parameter int IDXW = 4,
  parameter int INFL = 2,
  parameter int FLW  = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ack,
  input logic [31:0]     mem_addr,
  input logic            wb_rdy_bit,
  input logic            fifo_wr,
  input logic [FLW-1:0]  fifo_level,
  input logic [FLW-1:0]  fifo_bytes,
  input logic            ev_push,
  input logic            ev_pop,
  input logic            ev_w0_done,
  input logic [IDXW-1:0] cur_idx,
  input logic [IDXW-1:0] pop_idx
);

  logic [(1<<IDXW)-1:0] pend;
  logic [7:0]           pend_cnt;
  logic [9:0]           run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      pend_cnt <= '0;
      run_cnt  <= '0;
    end else begin
      if (ev_pop)  pend[pop_idx] <= 1'b0;
      if (ev_push) pend[cur_idx] <= 1'b1;
      pend_cnt <= pend_cnt + 8'(ev_push) - 8'(ev_pop);
      run_cnt  <= ev_push ? '0 : run_cnt + 10'(fifo_wr);
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11
  AST_FIFO_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> ({1'b0, fifo_level} + (FLW+1)'(4)) <= {1'b0, fifo_bytes}); // R5
  AST_WB_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !wb_rdy_bit); // R7
  AST_NO_REFETCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_w0_done |-> !pend[cur_idx]); // R10
  AST_LIST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= 8'(INFL)); // R10
  AST_CLAMP_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> run_cnt < 10'd508); // R6

endmodule

bind txring_prefetch txr_checker #(.IDXW(IDXW), .INFL(INFL), .FLW(FLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .wb_rdy_bit(mem_wdata[31]), .fifo_wr(fifo_wr),
  .fifo_level(fifo_level), .fifo_bytes(fifo_bytes), .ev_push(ev_push),
  .ev_pop(ev_pop), .ev_w0_done(ev_w0_done), .cur_idx(rd_cur_idx), .pop_idx(wb_idx)
);

// File: tb/txring_prefetch_tb.sv
`timescale 1ns/1ps
module txring_prefetch_tb;

  localparam int IDXW = 4;
  localparam int INFL = 2;
  localparam int FLW  = 12;
  localparam logic [31:0] BASE = 32'h100;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [31:0]     ring_base = BASE;
  logic [IDXW-1:0] ring_cnt = 4'd4;
  logic [FLW-1:0]  fifo_bytes = 12'd192;
  logic [FLW-1:0]  fifo_level = '0;
  logic            mem_req, mem_we, fifo_wr, fifo_eof, len_err;
  logic [31:0]     mem_addr, mem_wdata, fifo_data;
  logic            mem_ack = 1'b0;
  logic [31:0]     mem_rdata = '0;

  txring_prefetch #(.IDXW(IDXW), .INFL(INFL), .FLW(FLW)) u_dut (
    .clk, .rst_n, .start, .ring_base, .ring_cnt, .fifo_bytes, .fifo_level,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
    .fifo_wr, .fifo_data, .fifo_eof, .len_err
  );

  initial forever #2.5 clk = ~clk;

  logic [31:0] mem [0:1023];
  logic [31:0] fifo_log [0:1023];
  logic        eof_log  [0:1023];
  logic [31:0] wb_addr_log [0:63];
  logic [31:0] wb_data_log [0:63];
  int n_fifo, n_wb, n_lenerr, max_level, hold_viol;
  int any_cnt [0:15];
  int rdy_cnt [0:15];
  int n_tests = 0, n_fail = 0;
  logic prev_wait = 1'b0;
  logic [31:0] prev_addr = '0;
  logic drain_tick = 1'b0;

  function automatic logic [31:0] pat(logic [31:0] a);
    return 32'hC0DE0000 ^ a;
  endfunction

  function automatic logic [31:0] mk_w0(logic rdy, logic last, logic [10:0] len);
    return {rdy, 3'b000, last, 16'h0000, len};
  endfunction

  // memory responder, FIFO level model and event logs
  initial forever begin
    @(posedge clk);
    if (prev_wait && (!mem_req || mem_addr != prev_addr)) hold_viol++;
    prev_wait = mem_req && !mem_ack;
    prev_addr = mem_addr;
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        mem[mem_addr[11:2]] = mem_wdata;
        if (n_wb < 64) begin
          wb_addr_log[n_wb] = mem_addr;
          wb_data_log[n_wb] = mem_wdata;
        end
        n_wb++;
      end else if (mem_addr >= BASE && mem_addr < BASE + 128 && mem_addr[2] == 1'b0) begin
        any_cnt[(mem_addr - BASE) >> 3]++;
        if (mem_rdata[31]) rdy_cnt[(mem_addr - BASE) >> 3]++;
      end
    end
    if (fifo_wr && n_fifo < 1024) begin
      fifo_log[n_fifo] = fifo_data;
      eof_log[n_fifo]  = fifo_eof;
    end
    if (fifo_wr) n_fifo++;
    if (len_err) n_lenerr++;
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[11:2]];
    end else begin
      mem_ack   <= 1'b0;
    end
    begin
      int lv;
      lv = int'(fifo_level) + (fifo_wr ? 4 : 0);
      drain_tick = ~drain_tick;
      if (drain_tick && lv >= 4) lv -= 4;
      if (lv > max_level) max_level = lv;
      fifo_level <= FLW'(lv);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mem_init();
    for (int i = 0; i < 1024; i++) mem[i] = pat(32'(i) << 2);
  endtask

  task automatic set_desc(input int idx, input logic rdy, input logic last,
                          input logic [10:0] len, input logic [31:0] ptr);
    mem[(BASE + 32'(8*idx)) >> 2]     = mk_w0(rdy, last, len);
    mem[((BASE + 32'(8*idx)) >> 2) + 1] = ptr;
  endtask

  task automatic clear_logs();
    n_fifo = 0; n_wb = 0; n_lenerr = 0; max_level = 0;
    for (int i = 0; i < 16; i++) begin
      any_cnt[i] = 0;
      rdy_cnt[i] = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 32) begin
      @(negedge clk);
      if (mem_req) q = 0; else q++;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 mem_req after reset", 32'(mem_req), 0);
    chk("R1 fifo_wr after reset", 32'(fifo_wr), 0);
    chk("R1 len_err after reset", 32'(len_err), 0);
  endtask

  task automatic t_basic();
    mem_init();
    ring_cnt = 4'd4; fifo_bytes = 12'd192;
    set_desc(0, 1, 1, 11'd8, 32'h200);
    set_desc(1, 1, 1, 11'd5, 32'h240);
    set_desc(2, 0, 1, 11'd4, 32'h280);
    do_reset();
    clear_logs();
    pulse_start();
    wait_quiet();
    chk("R2 first descriptor at ring base read once", 32'(rdy_cnt[0]), 1);
    chk("R4 word count", 32'(n_fifo), 4);
    chk("R4 word0", fifo_log[0], pat(32'h200));
    chk("R4 word1", fifo_log[1], pat(32'h204));
    chk("R4 word2", fifo_log[2], pat(32'h240));
    chk("R4 word3", fifo_log[3], pat(32'h244));
    chk("R3 eof only on last word of frame A", {31'd0, eof_log[0]}, 0);
    chk("R3 eof on frame A end", {31'd0, eof_log[1]}, 1);
    chk("R3 eof on frame B end", {31'd0, eof_log[3]}, 1);
    chk("R7 write-back count", 32'(n_wb), 2);
    chk("R7 first write-back address", wb_addr_log[0], BASE);
    chk("R7 first write-back data", wb_data_log[0], mk_w0(0, 1, 11'd8));
    chk("R7 second write-back address", wb_addr_log[1], BASE + 8);
    chk("R7 second write-back data", wb_data_log[1], mk_w0(0, 1, 11'd5));
    chk("R9 stopped descriptor untouched", mem[(BASE + 16) >> 2], mk_w0(0, 1, 11'd4));
  endtask

  task automatic t_restart();
    clear_logs();
    set_desc(2, 1, 1, 11'd4, 32'h280);
    set_desc(3, 0, 1, 11'd4, 32'h2C0);
    pulse_start();
    repeat (3) @(negedge clk);
    pulse_start();
    wait_quiet();
    chk("R9 resume at stopped index", 32'(rdy_cnt[2]), 1);
    chk("R9 resume not at index 0", 32'(any_cnt[0]), 0);
    chk("R2 start while busy ignored", 32'(any_cnt[3]), 1);
    chk("R4 resumed data", fifo_log[0], pat(32'h280));
    chk("R4 resumed count", 32'(n_fifo), 1);
  endtask

  task automatic t_wrap();
    mem_init();
    ring_cnt = 4'd2; fifo_bytes = 12'd192;
    set_desc(0, 1, 0, 11'd4, 32'h200);
    set_desc(1, 1, 1, 11'd4, 32'h240);
    set_desc(2, 1, 1, 11'd4, 32'h280);
    do_reset();
    clear_logs();
    pulse_start();
    wait_quiet();
    chk("R4 spanning frame word count", 32'(n_fifo), 2);
    chk("R4 no eof mid frame", {31'd0, eof_log[0]}, 0);
    chk("R4 eof at frame end", {31'd0, eof_log[1]}, 1);
    chk("R10 index 0 ready read once", 32'(rdy_cnt[0]), 1);
    chk("R10 index 1 ready read once", 32'(rdy_cnt[1]), 1);
    chk("R8 wrapped back to index 0", 32'(any_cnt[0]), 2);
    chk("R8 index beyond ring not read", 32'(any_cnt[2]), 0);
    chk("R7 both written back", 32'(n_wb), 2);
  endtask

  task automatic t_single();
    mem_init();
    ring_cnt = 4'd1; fifo_bytes = 12'd192;
    set_desc(0, 1, 1, 11'd12, 32'h300);
    set_desc(1, 1, 1, 11'd4, 32'h340);
    do_reset();
    clear_logs();
    pulse_start();
    wait_quiet();
    chk("R10 single-entry ring frame sent once", 32'(n_fifo), 3);
    chk("R10 ready read once", 32'(rdy_cnt[0]), 1);
    chk("R8 re-read after write-back", 32'(any_cnt[0]), 2);
    chk("R8 ring of one never reads index 1", 32'(any_cnt[1]), 0);
  endtask

  task automatic t_zero();
    mem_init();
    ring_cnt = 4'd4; fifo_bytes = 12'd192;
    set_desc(0, 1, 1, 11'd0, 32'h200);
    set_desc(1, 0, 1, 11'd4, 32'h240);
    do_reset();
    clear_logs();
    pulse_start();
    wait_quiet();
    chk("R12 zero length no fifo writes", 32'(n_fifo), 0);
    chk("R12 zero length written back", 32'(n_wb), 1);
    chk("R12 ready cleared", mem[BASE >> 2], mk_w0(0, 1, 11'd0));
  endtask

  task automatic t_clamp();
    mem_init();
    ring_cnt = 4'd4; fifo_bytes = 12'd16;
    set_desc(0, 1, 1, 11'd2040, 32'h800);
    set_desc(1, 0, 1, 11'd4, 32'h240);
    do_reset();
    clear_logs();
    pulse_start();
    wait_quiet();
    chk("R6 clamped word count", 32'(n_fifo), 508);
    chk("R6 len_err pulses once", 32'(n_lenerr), 1);
    chk("R5 level never above capacity", 32'(max_level <= 16), 1);
    chk("R4 first clamped word", fifo_log[0], pat(32'h800));
    chk("R4 last clamped word", fifo_log[507], pat(32'h800 + 32'd2028));
    chk("R4 eof on clamped last word", {31'd0, eof_log[507]}, 1);
    chk("R7 clamped write-back keeps length", wb_data_log[0], mk_w0(0, 1, 11'd2040));
    fifo_bytes = 12'd192;
  endtask

  initial begin
    hold_viol = 0;
    clear_logs();
    mem_init();
    t_reset();
    t_basic();
    t_restart();
    t_wrap();
    t_single();
    t_zero();
    t_clamp();
    chk("R11 request held until ack", 32'(hold_viol), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule